// File: doc/BRIEF.md
# SDIO Extended Transfer Sequencer

This block walks through the bytes of one multi-byte or multi-block I/O data transfer once a command decoder has parsed it. The command gives the direction, the target function, whether the count is in blocks or bytes, whether the register address stays fixed or increments, a 17-bit start address and a 9-bit count. For every byte the sequencer presents a register address and a one-cycle strobe to the function's register or FIFO interface. It also marks the first and last byte of each block for the data-line layer, which serializes the bytes and computes CRC.

Block lengths come from a table of per-function block-size registers that sits outside the block, one 12-bit entry per function. Function 0 has its own entry at index 0. A byte-mode transfer is treated as one block. Aborts arrive as a one-cycle pulse when the abort field of the control register is written. A read stops two cycles after the abort. A write finishes the block in progress and its CRC status, then holds busy until the function reports that the last block has been processed.

Top module: `sdio_xfer_seq`

## Requirements
- R1: With the fixed-address op code (`cmdIncr`=0), every byte strobe of the transfer carries the start address.
- R2: With the incrementing op code (`cmdIncr`=1), byte n (counting from 0) carries start address + n, modulo 2^17.
- R3: In block mode (`cmdBlockMode`=1) the transfer is `cmdCount` blocks of S bytes each. S is entry `cmdFunc` of `blkSizeTable`, held in bits [12*f+11:12*f] and taken when the command is accepted. `blockStart` and `blockEnd` are high together with the strobe of the first and of the last byte of each block.
- R4: In byte mode the transfer is one block of `cmdCount` bytes (1 to 511). A count of 0 means 512 bytes.
- R5: In block mode a count of 0 gives an unbounded transfer that ends only through an abort.
- R6: For a read, an abort pulse in cycle t allows strobes in cycles t and t+1. From cycle t+2 there is no strobe, and `done` pulses in cycle t+2 unless the transfer already finished.
- R7: For a write, an abort does not cut the current block short. The block completes, including its `crcAck`. From the next cycle `busy` stays high with no strobes until `procDone`, and `done` pulses in the `procDone` cycle.
- R8: For a write, after the last byte of each block no strobe occurs until `crcAck`. In a bounded transfer, `done` pulses in the cycle `crcAck` arrives for the final block.
- R9: For a read, `done` pulses in the same cycle as the strobe of the final byte. `done` never stays high for two cycles in a row.
- R10: After reset the block is idle, with `active`, `byteStrobe`, `busy` and `done` low. A command is taken only while idle, and `cmdValid` during a transfer has no effect.
- R11: A byte strobe occurs only in a cycle where `byteReady` is high. A running transfer strobes in every such cycle unless R6, R7 or R8 holds it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Parsed command present |
| cmdWrite | input | 1 | 1 = write to card, 0 = read from card |
| cmdFunc | input | 3 | Function number |
| cmdBlockMode | input | 1 | 1 = count is in blocks |
| cmdIncr | input | 1 | Op code: 1 = incrementing address |
| cmdAddr | input | 17 | Start register address |
| cmdCount | input | 9 | Byte or block count |
| blkSizeTable | input | 96 | Per-function block sizes, 12 bits per function |
| byteReady | input | 1 | Data-line layer can move a byte this cycle |
| abortReq | input | 1 | Abort written to the control register (pulse) |
| crcAck | input | 1 | CRC status of the last write block completed |
| procDone | input | 1 | Function has finished processing the last write block |
| active | output | 1 | A transfer is in progress |
| byteStrobe | output | 1 | One byte is transferred this cycle |
| byteWrite | output | 1 | Direction of the current transfer |
| byteFunc | output | 3 | Function of the current transfer |
| byteAddr | output | 17 | Register address of this byte |
| blockStart | output | 1 | This byte opens a block |
| blockEnd | output | 1 | This byte closes a block |
| busy | output | 1 | Write-abort busy period |
| done | output | 1 | Transfer finished or abort completed (pulse) |

## Verification
The properties take for granted that block-size entries lie between 1 and 2048 and stay unchanged while a transfer is running. They also assume `crcAck` comes only after a write block has ended, `procDone` only during busy, and `abortReq` only as single-cycle pulses. The stimulus draws sizes from a fixed table within that range. It raises `crcAck` and `procDone` only in the phases where the bench's own model expects the block to be waiting. Random `cmdValid` pulses with random fields are mixed in during transfers, so the check that such commands are ignored is exercised without breaking these assumptions.

// File: rtl/sdio_xfer_pkg.sv
package sdio_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_WCRC  = 2'd2,
    ST_WBUSY = 2'd3
  } xferState_t;

  typedef struct packed {
    logic load;     // capture the command
    logic step;     // one byte moved
    logic nextBlk;  // reload the byte counter for the next block
  } dpCtrl_t;

endpackage

// File: rtl/sdio_xfer_dp.sv
module sdio_xfer_dp
  import sdio_xfer_pkg::*;
#(
  parameter int FUNC_W   = 3,
  parameter int ADDR_W   = 17,
  parameter int CNT_W    = 9,
  parameter int BS_W     = 12,
  parameter int BYTE_MAX = 512
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpCtrl_t                       ctrl,
  input  logic [FUNC_W-1:0]             cmdFunc,
  input  logic                          cmdBlockMode,
  input  logic                          cmdIncr,
  input  logic [ADDR_W-1:0]             cmdAddr,
  input  logic [CNT_W-1:0]              cmdCount,
  input  logic [(1<<FUNC_W)*BS_W-1:0]   blkSizeTable,
  output logic [ADDR_W-1:0]             addr,
  output logic [FUNC_W-1:0]             func,
  output logic                          firstInBlk,
  output logic                          lastInBlk,
  output logic                          lastBlk
);

  localparam int NUM_FUNC = 1 << FUNC_W;

  logic [BS_W-1:0]  blkLen, byteLeft, selSize, startLen;
  logic [CNT_W-1:0] blkLeft;
  logic             incr, infinite;

  always_comb begin
    selSize = '0;
    for (int f = 0; f < NUM_FUNC; f++) begin
      if (cmdFunc == FUNC_W'(f)) selSize = blkSizeTable[f*BS_W +: BS_W];
    end
    if (cmdBlockMode)          startLen = selSize;
    else if (cmdCount == '0)   startLen = BS_W'(BYTE_MAX);
    else                       startLen = BS_W'(cmdCount);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr     <= '0;
      func     <= '0;
      blkLen   <= '0;
      byteLeft <= '0;
      blkLeft  <= '0;
      incr     <= 1'b0;
      infinite <= 1'b0;
    end else if (ctrl.load) begin
      addr     <= cmdAddr;
      func     <= cmdFunc;
      incr     <= cmdIncr;
      blkLen   <= startLen;
      byteLeft <= startLen;
      blkLeft  <= cmdBlockMode ? cmdCount : CNT_W'(1);
      infinite <= cmdBlockMode && (cmdCount == '0);
    end else begin
      if (ctrl.step) begin
        if (incr) addr <= addr + ADDR_W'(1);
        byteLeft <= byteLeft - BS_W'(1);
      end
      if (ctrl.nextBlk) begin
        byteLeft <= blkLen;
        if (!infinite) blkLeft <= blkLeft - CNT_W'(1);
      end
    end
  end

  assign firstInBlk = (byteLeft == blkLen);
  assign lastInBlk  = (byteLeft == BS_W'(1));
  assign lastBlk    = !infinite && (blkLeft == CNT_W'(1));

endmodule

// File: rtl/sdio_xfer_ctrl.sv
module sdio_xfer_ctrl
  import sdio_xfer_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  logic    cmdWrite,
  input  logic    byteReady,
  input  logic    abortReq,
  input  logic    crcAck,
  input  logic    procDone,
  input  logic    lastInBlk,
  input  logic    lastBlk,
  output dpCtrl_t ctrl,
  output logic    active,
  output logic    strobe,
  output logic    isWrite,
  output logic    busy,
  output logic    done
);

  xferState_t state, nextState;
  logic [1:0] abortCnt;
  logic       pend, readStop;

  assign readStop = !isWrite && (abortCnt == 2'd2);
  assign strobe   = (state == ST_RUN) && byteReady && !readStop;
  assign active   = (state != ST_IDLE);
  assign busy     = (state == ST_WBUSY);

  always_comb begin
    nextState = state;
    ctrl      = '0;
    done      = 1'b0;
    case (state)
      ST_IDLE: if (cmdValid) begin
        ctrl.load = 1'b1;
        nextState = ST_RUN;
      end
      ST_RUN: begin
        if (readStop) begin
          done      = 1'b1;
          nextState = ST_IDLE;
        end else if (strobe) begin
          ctrl.step = 1'b1;
          if (lastInBlk) begin
            if (isWrite) nextState = ST_WCRC;
            else if (lastBlk) begin
              done      = 1'b1;
              nextState = ST_IDLE;
            end else ctrl.nextBlk = 1'b1;
          end
        end
      end
      ST_WCRC: if (crcAck) begin
        if (pend || abortReq) nextState = ST_WBUSY;
        else if (lastBlk) begin
          done      = 1'b1;
          nextState = ST_IDLE;
        end else begin
          ctrl.nextBlk = 1'b1;
          nextState    = ST_RUN;
        end
      end
      ST_WBUSY: if (procDone) begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      isWrite  <= 1'b0;
      abortCnt <= 2'd0;
      pend     <= 1'b0;
    end else begin
      state <= nextState;
      if (ctrl.load) isWrite <= cmdWrite;
      if (state != ST_RUN || nextState != ST_RUN) abortCnt <= 2'd0;
      else if (abortCnt != 2'd0) abortCnt <= abortCnt + 2'd1;
      else if (abortReq && !isWrite) abortCnt <= 2'd1;
      if (ctrl.load || nextState == ST_IDLE) pend <= 1'b0;
      else if (abortReq && isWrite && (state == ST_RUN || state == ST_WCRC)) pend <= 1'b1;
    end
  end

endmodule

// File: rtl/sdio_xfer_seq.sv
module sdio_xfer_seq
  import sdio_xfer_pkg::*;
#(
  parameter int FUNC_W   = 3,
  parameter int ADDR_W   = 17,
  parameter int CNT_W    = 9,
  parameter int BS_W     = 12,
  parameter int BYTE_MAX = 512
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmdValid,
  input  logic                        cmdWrite,
  input  logic [FUNC_W-1:0]           cmdFunc,
  input  logic                        cmdBlockMode,
  input  logic                        cmdIncr,
  input  logic [ADDR_W-1:0]           cmdAddr,
  input  logic [CNT_W-1:0]            cmdCount,
  input  logic [(1<<FUNC_W)*BS_W-1:0] blkSizeTable,
  input  logic                        byteReady,
  input  logic                        abortReq,
  input  logic                        crcAck,
  input  logic                        procDone,
  output logic                        active,
  output logic                        byteStrobe,
  output logic                        byteWrite,
  output logic [FUNC_W-1:0]           byteFunc,
  output logic [ADDR_W-1:0]           byteAddr,
  output logic                        blockStart,
  output logic                        blockEnd,
  output logic                        busy,
  output logic                        done
);

  dpCtrl_t ctrl;
  logic    firstInBlk, lastInBlk, lastBlk;

  sdio_xfer_ctrl u_ctrl (
    .clk, .rstN, .cmdValid, .cmdWrite, .byteReady, .abortReq, .crcAck, .procDone,
    .lastInBlk, .lastBlk, .ctrl, .active, .strobe(byteStrobe), .isWrite(byteWrite),
    .busy, .done
  );

  sdio_xfer_dp #(
    .FUNC_W(FUNC_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BS_W(BS_W), .BYTE_MAX(BYTE_MAX)
  ) u_dp (
    .clk, .rstN, .ctrl, .cmdFunc, .cmdBlockMode, .cmdIncr, .cmdAddr, .cmdCount,
    .blkSizeTable, .addr(byteAddr), .func(byteFunc), .firstInBlk, .lastInBlk, .lastBlk
  );

  assign blockStart = byteStrobe && firstInBlk;
  assign blockEnd   = byteStrobe && lastInBlk;

endmodule

// File: rtl/sdio_xfer_seq_chk.sv
module sdio_xfer_seq_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdIncr,
  input logic              active,
  input logic              byteReady,
  input logic              byteStrobe,
  input logic [ADDR_W-1:0] byteAddr,
  input logic              blockStart,
  input logic              blockEnd,
  input logic              busy,
  input logic              done
);

  logic              curIncr, haveLast;
  logic [ADDR_W-1:0] lastAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIncr  <= 1'b0;
      haveLast <= 1'b0;
      lastAddr <= '0;
    end else if (cmdValid && !active) begin
      curIncr  <= cmdIncr;
      haveLast <= 1'b0;
    end else if (byteStrobe) begin
      haveLast <= 1'b1;
      lastAddr <= byteAddr;
    end
  end

  AST_FIXED_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (byteStrobe && haveLast && !curIncr) |-> byteAddr == lastAddr); // R1
  AST_INCR_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (byteStrobe && haveLast && curIncr) |-> byteAddr == ADDR_W'(lastAddr + ADDR_W'(1))); // R2
  AST_MARK_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (blockStart || blockEnd) |-> byteStrobe); // R3
  AST_BUSY_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !byteStrobe); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !(byteStrobe || busy || done)); // R10
  AST_STROBE_READY: assert property (@(posedge clk) disable iff (!rstN)
    byteStrobe |-> byteReady); // R11

endmodule

bind sdio_xfer_seq sdio_xfer_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sdio_xfer_seq_bench.sv
module sdio_xfer_seq_bench;

  localparam int AMASK = (1 << 17) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdWrite = 1'b0, cmdBlockMode = 1'b0, cmdIncr = 1'b0;
  logic [2:0]  cmdFunc = '0;
  logic [16:0] cmdAddr = '0;
  logic [8:0]  cmdCount = '0;
  logic [95:0] blkSizeTable;
  logic        byteReady = 1'b0, abortReq = 1'b0, crcAck = 1'b0, procDone = 1'b0;
  logic        active, byteStrobe, byteWrite, blockStart, blockEnd, busy, done;
  logic [2:0]  byteFunc;
  logic [16:0] byteAddr;

  int nChk = 0, nBad = 0, cycles = 0;
  int bsTab [8] = '{16, 1, 5, 300, 7, 64, 3, 33};

  always #10 clk = ~clk;

  sdio_xfer_seq u_sdio_xfer_seq (.*);

  initial for (int f = 0; f < 8; f++) blkSizeTable[f*12 +: 12] = 12'(bsTab[f]);

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expAddr(input bit inc, input int start, input int idx);
    return inc ? ((start + idx) & AMASK) : start;
  endfunction

  task automatic runXfer(input bit wr, input int fn, input bit blk, input bit inc,
                         input int addr, input int cnt, input int abortAt);
    int bs, total, idx, cyc, phase, crcWait, busyWait, abortCyc;
    bit pend, fin, inf, eStrobe, eDone, eBusy, eBS, eBE;
    string doneReq, strobeReq;
    bs    = blk ? bsTab[fn] : (cnt == 0 ? 512 : cnt);
    inf   = blk && cnt == 0;
    total = blk ? cnt * bs : bs;
    doneReq = wr ? "R8" : "R9";
    if (abortAt >= 0) doneReq = wr ? "R7" : "R6";
    if (inf) doneReq = "R5";
    idx = 0; cyc = 0; phase = 0; crcWait = 0; busyWait = 0; abortCyc = -10;
    pend = 0; fin = 0;
    @(negedge clk);
    cmdValid = 1; cmdWrite = wr; cmdFunc = 3'(fn); cmdBlockMode = blk; cmdIncr = inc;
    cmdAddr = 17'(addr); cmdCount = 9'(cnt); byteReady = 0; abortReq = 0;
    while (!fin && cyc < 20000) begin
      @(negedge clk);
      cmdValid = ($urandom % 8) == 0;        // ignored while running (R10)
      cmdAddr = 17'($urandom); cmdCount = 9'($urandom); cmdIncr = 1'($urandom);
      cmdWrite = 1'($urandom); cmdBlockMode = 1'($urandom);
      byteReady = ($urandom % 4) != 0;
      abortReq = 0; crcAck = 0; procDone = 0;
      if (cyc == abortAt) begin
        abortReq = 1;
        if (!wr && phase == 0) abortCyc = cyc;
        if (wr && phase < 2) pend = 1;
      end
      if (phase == 1 && crcWait == 0) crcAck = 1;
      if (phase == 2 && busyWait == 0) procDone = 1;
      #1;
      eStrobe = 0; eDone = 0; eBS = 0; eBE = 0;
      eBusy = (phase == 2);
      strobeReq = (phase == 1) ? "R8" : (phase == 2) ? "R7" : "R11";
      case (phase)
        0: if (!wr && cyc == abortCyc + 2) begin
             strobeReq = "R6"; eDone = 1; fin = 1;
           end else if (byteReady) begin
             eStrobe = 1;
             chk(inc ? "R2" : "R1", int'(byteAddr), expAddr(inc, addr, idx));
             eBS = (idx % bs) == 0;
             eBE = (idx % bs) == bs - 1;
             idx++;
             if (eBE) begin
               if (wr) begin phase = 1; crcWait = $urandom % 3; end
               else if (!inf && idx == total) begin eDone = 1; fin = 1; end
             end
           end
        1: if (crcAck) begin
             if (pend) begin phase = 2; busyWait = $urandom % 4; end
             else if (!inf && idx == total) begin eDone = 1; fin = 1; end
             else phase = 0;
           end else crcWait--;
        default: if (procDone) begin eDone = 1; fin = 1; end
                 else busyWait--;
      endcase
      chk(strobeReq, int'(byteStrobe), int'(eStrobe));
      chk(blk ? "R3" : "R4", int'(blockStart), int'(eBS));
      chk(blk ? "R3" : "R4", int'(blockEnd), int'(eBE));
      chk(doneReq, int'(done), int'(eDone));
      chk("R7", int'(busy), int'(eBusy));
      cyc++;
    end
    if (!fin) chk("R9 transfer never finished", 0, 1);
    @(negedge clk);
    cmdValid = 0; byteReady = 0; abortReq = 0; crcAck = 0; procDone = 0;
    #1;
    chk("R10", int'(active), 0);
    chk("R10", int'(done), 0);
  endtask

  initial begin
    while (cycles < 190000) begin
      @(posedge clk);
      cycles++;
    end
    nChk++; nBad++;
    $display("FAIL watchdog actual=%0d expected<%0d", cycles, 190000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R10", int'(active), 0);
    chk("R10", int'(byteStrobe), 0);
    chk("R10", int'(busy), 0);
    chk("R10", int'(done), 0);
    rstN = 1'b1;
    // directed corners
    runXfer(0, 0, 0, 0, 'h123, 3, -1);          // R1 fixed address, byte mode
    runXfer(0, 0, 0, 1, 'h40, 0, -1);           // R4 count 0 -> 512, R2
    runXfer(0, 0, 0, 1, 'h1FFFE, 5, -1);        // R2 wrap at 17 bits
    runXfer(0, 0, 1, 1, 'h200, 2, -1);          // R3 function 0 size
    runXfer(0, 1, 1, 0, 'h7, 3, -1);            // R3 one-byte blocks
    runXfer(0, 3, 1, 1, 'h1000, 1, -1);         // R3 large block
    runXfer(1, 2, 1, 1, 'h55, 3, -1);           // R8 write blocks
    runXfer(1, 0, 0, 0, 'h10, 9, -1);           // R8 byte-mode write
    runXfer(0, 2, 1, 1, 'h300, 0, 40);          // R5 + R6 unbounded read abort
    runXfer(0, 5, 1, 1, 'h0, 2, 3);             // R6 early read abort
    runXfer(1, 0, 1, 1, 'h80, 0, 30);           // R5 + R7 unbounded write abort
    runXfer(1, 1, 1, 0, 'h90, 0, 4);            // R7 abort with one-byte blocks
    // constrained random
    for (int i = 0; i < 40; i++) begin
      bit wr, blk, inc;
      int fn, cnt, ab;
      wr  = 1'($urandom);
      blk = 1'($urandom);
      inc = 1'($urandom);
      fn  = (blk && ($urandom % 3 == 0)) ? 0 : int'($urandom % 8);
      if (fn == 3) fn = 4;
      cnt = blk ? 1 + int'($urandom % 4) : 1 + int'($urandom % 40);
      ab  = ($urandom % 4 == 0) ? int'($urandom % 60) : -1;
      runXfer(wr, fn, blk, inc, int'($urandom) & AMASK, cnt, ab);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule